// File: doc/BRIEF.md
# SMBus Register-Read Slave with Power-Gated Interrupt Flag

This block is an SMBus slave. It oversamples the SCL and SDA lines with the system clock and pulls SDA low through an open-drain output when it has to drive the bus. An external controller reads one of its internal bytes with a combined-format transfer. The controller first writes an 8-bit command code that picks the byte. It then issues a repeated START, readdresses the slave with the read bit set, and clocks the chosen byte out of the slave, most significant bit first.

The same first half of a transfer, ended by a STOP instead of a repeated START, forms a short command message. When the command code is the interrupt-request code, the block sets a sticky status flag. It does this only while the host power state is S0. In any sleep state the message is still acknowledged, but the flag keeps its value. The flag stays set across power transitions until the clear input is asserted.

Top module: `smb_regread_slave`

## Requirements
- R1: After reset, `sda_pull` is 0 (SDA released) and `smi_sts` is 0.
- R2: In the first address phase the slave acknowledges only when the 7 address bits equal `own_addr` and the eighth bit (R/W) is 0. On any other address byte it does not pull SDA low at any point until the next START or STOP.
- R3: After an accepted address, the slave acknowledges the 8-bit command byte. After a repeated START, a matching address with R/W = 1 and an acknowledge, the slave drives the byte `reg_values[8*c +: 8]` for command code c < NREG. The byte goes out most significant bit first.
- R4: For command codes c >= NREG (default NREG = 8), the data byte reads as 00h.
- R5: After a repeated START, an address byte that mismatches `own_addr` or has R/W = 0 is not acknowledged, and no data bit is driven afterwards.
- R6: A command message (START, address with R/W = 0, command byte, STOP) carrying code 08h sets `smi_sts` when `pwr_state` is 0 (S0) at the STOP.
- R7: A code 08h message received while `pwr_state` is 1 to 5 (S1 to S5) is still acknowledged in both bytes, and `smi_sts` is unchanged.
- R8: Command messages with any code other than 08h, including the reserved codes 09h to FFh, leave `smi_sts` unchanged.
- R9: `smi_sts` holds its value through changes of `pwr_state` and clears only when `smi_clr` is high.
- R10: When a set and `smi_clr` fall on the same clock, the set wins.
- R11: A START or STOP in the middle of a byte abandons the transfer and restarts bit counting. A complete transfer that follows works normally.
- R12: SDA changes only while SCL is low. After the master's NOT-ACK following the data byte, SDA stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level (wired-AND bus) |
| own_addr | input | 7 | Programmable receive address |
| pwr_state | input | 3 | Host power state: 0 = S0, 1..5 = S1..S5 |
| reg_values | input | NREG*8 | Readable bytes; byte c at bits 8c+7..8c |
| smi_clr | input | 1 | Clears the interrupt status flag |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| smi_sts | output | 1 | Sticky interrupt-request status flag |

## Verification
The assertions assume that the controller follows the bus protocol. It changes SDA only while SCL is low, except to form START and STOP conditions. It never attempts a START or STOP while the slave holds SDA low. Each SCL level lasts several system clocks, so every edge survives the two-stage synchronizer. The bench models the bus as a wired-AND of the master's drive and the slave's pull. Every SCL and SDA phase lasts four clocks, and a START or STOP is issued only after the master has released SDA, so the stimulus stays within these assumptions.

// File: rtl/smb_regread_slave.sv
module smb_regread_slave #(
  parameter int         NREG    = 8,
  parameter logic [7:0] SMI_CMD = 8'h08
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_in,
  input  logic            sda_in,
  input  logic [6:0]      own_addr,
  input  logic [2:0]      pwr_state,
  input  logic [NREG*8-1:0] reg_values,
  input  logic            smi_clr,
  output logic            sda_pull,
  output logic            smi_sts
);

  typedef enum logic [3:0] {
    IDLE, ADDR, ADDR_CHK, ADDR_ACK, CMD, CMD_CHK, CMD_ACK, WAIT, TX, MACK, IGN
  } st_t;

  st_t        st;
  logic       scl_m, scl_s, scl_q, sda_m, sda_s, sda_q;
  logic [2:0] cnt;
  logic [7:0] sh, cmd, tx, rd_byte;
  logic       rs, pull, smi;

  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire addr_ok  = (sh[7:1] == own_addr) && (sh[0] == rs);
  wire smi_set  = stop_c && (st == WAIT) && (cmd == SMI_CMD) && (pwr_state == 3'd0);

  always_comb begin
    rd_byte = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (cmd == 8'(i)) rd_byte = reg_values[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {scl_m, scl_s, scl_q, sda_m, sda_s, sda_q} <= '1;
      st <= IDLE; cnt <= '0; sh <= '0; cmd <= '0; tx <= '0;
      rs <= 1'b0; pull <= 1'b0; smi <= 1'b0;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_q <= sda_s;
      smi   <= (smi & ~smi_clr) | smi_set;
      if (stop_c) begin
        st <= IDLE; pull <= 1'b0;
      end else if (start_c) begin
        st <= ADDR; cnt <= '0; rs <= (st == WAIT); pull <= 1'b0;
      end else begin
        case (st)
          ADDR, CMD: if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= 3'(cnt + 3'd1);
            if (cnt == 3'd7) st <= (st == ADDR) ? ADDR_CHK : CMD_CHK;
          end
          ADDR_CHK: if (scl_fall) begin
            if (addr_ok) begin pull <= 1'b1; st <= ADDR_ACK; end
            else st <= IGN;
          end
          ADDR_ACK: if (scl_fall) begin
            cnt <= '0;
            if (rs) begin tx <= rd_byte; pull <= ~rd_byte[7]; st <= TX; end
            else begin pull <= 1'b0; st <= CMD; end
          end
          CMD_CHK: if (scl_fall) begin cmd <= sh; pull <= 1'b1; st <= CMD_ACK; end
          CMD_ACK: if (scl_fall) begin pull <= 1'b0; st <= WAIT; end
          TX: if (scl_fall) begin
            cnt <= 3'(cnt + 3'd1);
            if (cnt == 3'd7) begin pull <= 1'b0; st <= MACK; end
            else begin tx <= {tx[6:0], 1'b0}; pull <= ~tx[6]; end
          end
          MACK: if (scl_rise) st <= IDLE;
          default: ;
        endcase
      end
    end
  end

  assign sda_pull = pull;
  assign smi_sts  = smi;

  assert_sda_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> !$past(scl_s));
  assert_no_pull_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IGN) |-> !sda_pull);
  assert_set_only_s0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_sts) |-> ($past(pwr_state) == 3'd0));
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smi_sts) |-> $past(smi_clr));
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    smi_set |=> smi_sts);
  assert_idle_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == MACK || st == WAIT || st == IDLE) |-> !sda_pull);

endmodule

// File: tb/smb_regread_slave_tb.sv
module smb_regread_slave_tb;
  localparam int NREG = 8;
  localparam int Q = 4;

  logic clk = 0, rst_n = 0;
  logic scl = 1, m_sda = 1, smi_clr = 0;
  logic [6:0] own_addr = 7'h2A;
  logic [2:0] pwr_state = 0;
  logic [NREG*8-1:0] regs;
  logic sda_pull, smi_sts;
  wire  sda_bus = m_sda & ~sda_pull;
  int checks = 0, errors = 0, pull_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (sda_pull) pull_cnt <= pull_cnt + 1;

  smb_regread_slave #(.NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .own_addr(own_addr),
    .pwr_state(pwr_state), .reg_values(regs), .smi_clr(smi_clr),
    .sda_pull(sda_pull), .smi_sts(smi_sts));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); m_sda = 1; q(); scl = 1; q(); m_sda = 0; q(); scl = 0; q(); endtask
  task automatic i2c_stop(bit clr = 0);
    m_sda = 0; q(); scl = 1; q(); m_sda = 1;
    if (clr) begin smi_clr = 1; repeat (3) @(negedge clk); smi_clr = 0; end
    q();
  endtask
  task automatic send_bit(bit b); m_sda = b; q(); scl = 1; q(); q(); scl = 0; q(); endtask
  task automatic read_bit(output bit b); m_sda = 1; q(); scl = 1; q(); b = sda_bus; q(); scl = 0; q(); endtask
  task automatic send_byte(logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(b); ack = !b;
  endtask
  task automatic read_byte(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin read_bit(b); v[i] = b; end
    send_bit(1'b1);
  endtask

  task automatic do_read(logic [7:0] a1, logic [7:0] code, logic [7:0] a2,
                         output bit k1, output bit k2, output bit k3, output logic [7:0] d);
    i2c_start(); send_byte(a1, k1); send_byte(code, k2);
    i2c_start(); send_byte(a2, k3); read_byte(d); i2c_stop();
  endtask

  task automatic do_msg(logic [7:0] a, logic [7:0] code, bit clr, output bit k1, output bit k2);
    i2c_start(); send_byte(a, k1); send_byte(code, k2); i2c_stop(clr); q();
  endtask

  task automatic clear_smi(); @(negedge clk); smi_clr = 1; @(negedge clk); smi_clr = 0; endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit k1, k2, k3;
    logic [7:0] d, exp;
    int p0;
    for (int i = 0; i < NREG; i++) regs[i*8 +: 8] = 8'(8'h3C ^ (i * 37));
    repeat (3) @(negedge clk);
    chk("R1 sda_pull", sda_pull, 0); chk("R1 smi_sts", smi_sts, 0);
    rst_n = 1; q();
    chk("R1 sda_pull after reset", sda_pull, 0); chk("R1 smi_sts after reset", smi_sts, 0);

    // R3/R4: sweep command codes under two register patterns
    for (int pat = 0; pat < 2; pat++) begin
      if (pat == 1) for (int i = 0; i < NREG; i++) regs[i*8 +: 8] = 8'(255 - i * 29);
      for (int c = 0; c < 18; c++) begin
        logic [7:0] code = (c < 16) ? 8'(c) : ((c == 16) ? 8'h80 : 8'hFF);
        exp = (code < NREG) ? regs[code*8 +: 8] : 8'h00;
        do_read({own_addr, 1'b0}, code, {own_addr, 1'b1}, k1, k2, k3, d);
        chk("R2 address ack", k1, 1); chk("R3 command ack", k2, 1);
        chk("R3 read address ack", k3, 1);
        chk(code < NREG ? "R3 data byte" : "R4 unimplemented reads 00h", d, exp);
        chk("R12 released after nack", sda_pull, 0);
      end
    end

    // R2: several own addresses, mismatching first-phase bytes
    for (int a = 0; a < 4; a++) begin
      own_addr = 7'(7'h11 + a * 23);
      p0 = pull_cnt;
      i2c_start(); send_byte({own_addr ^ 7'h01, 1'b0}, k1); send_byte(8'h02, k2); i2c_stop();
      chk("R2 mismatch no ack", k1, 0); chk("R2 mismatch never pulls", pull_cnt - p0, 0);
      p0 = pull_cnt;
      i2c_start(); send_byte({own_addr, 1'b1}, k1); i2c_stop();
      chk("R2 read bit first phase no ack", k1, 0); chk("R2 no pull on R/W=1", pull_cnt - p0, 0);
      do_read({own_addr, 1'b0}, 8'(a), {own_addr, 1'b1}, k1, k2, k3, d);
      chk("R2 matching address ack", k1, 1); chk("R3 data after addr change", d, regs[a*8 +: 8]);
    end

    // R5: repeated-start address mismatch / wrong direction
    do_read({own_addr, 1'b0}, 8'h01, {own_addr ^ 7'h40, 1'b1}, k1, k2, k3, d);
    chk("R5 wrong address no ack", k3, 0); chk("R5 no data driven", d, 8'hFF);
    do_read({own_addr, 1'b0}, 8'h01, {own_addr, 1'b0}, k1, k2, k3, d);
    chk("R5 R/W=0 after restart no ack", k3, 0); chk("R5 no data driven R/W=0", d, 8'hFF);

    // R6/R7/R8: command messages across power states and codes
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < 5; c++) begin
        logic [7:0] code;
        case (c) 0: code = 8'h00; 1: code = 8'h07; 2: code = 8'h08; 3: code = 8'h09; default: code = 8'hFF; endcase
        clear_smi();
        pwr_state = 3'(p);
        do_msg({own_addr, 1'b0}, code, 0, k1, k2);
        chk("R7 message address ack", k1, 1); chk("R7 message command ack", k2, 1);
        chk(code == 8'h08 ? (p == 0 ? "R6 set in S0" : "R7 no set in sleep") : "R8 other code no effect",
            smi_sts, (code == 8'h08 && p == 0));
      end
    end

    // R8: flag already set stays set after reserved codes
    pwr_state = 0; do_msg({own_addr, 1'b0}, 8'h08, 0, k1, k2);
    do_msg({own_addr, 1'b0}, 8'hA5, 0, k1, k2);
    chk("R8 reserved code keeps flag", smi_sts, 1);

    // R9: sticky across power states
    pwr_state = 3; repeat (20) @(negedge clk); chk("R9 held in S3", smi_sts, 1);
    pwr_state = 5; repeat (20) @(negedge clk); chk("R9 held in S5", smi_sts, 1);
    pwr_state = 0; repeat (20) @(negedge clk); chk("R9 held back in S0", smi_sts, 1);
    clear_smi(); @(negedge clk); chk("R9 clear", smi_sts, 0);

    // R10: set and clear on the same clock
    do_msg({own_addr, 1'b0}, 8'h08, 1, k1, k2);
    chk("R10 set wins over clear", smi_sts, 1);
    clear_smi();

    // R11: aborted transfers
    i2c_start(); send_bit(own_addr[6]); send_bit(own_addr[5]); send_bit(own_addr[4]); i2c_stop();
    do_read({own_addr, 1'b0}, 8'h05, {own_addr, 1'b1}, k1, k2, k3, d);
    chk("R11 read after stop abort", d, regs[5*8 +: 8]);
    i2c_start(); send_bit(1'b1); send_bit(1'b0);
    do_read({own_addr, 1'b0}, 8'h06, {own_addr, 1'b1}, k1, k2, k3, d);
    chk("R11 read after start abort", d, regs[6*8 +: 8]);
    chk("R12 final release", sda_pull, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule